// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Aligner and Corrector

This block sits behind a three-stage pipelined analog-to-digital front end. Each stage resolves a coarse code for the same sample, but at a different moment: the first stage half a clock after the sampling edge, the second a full clock after it, and the last stage one and a half clocks after it. The aligner captures each code on the clock edge that matches its moment, then retimes the falling-edge captures into the rising-edge domain. This lines up the three codes of one sample so they can be merged.

The merged value treats the stages as overlapping digit positions. The gain between stages is four, and one bit of each later stage is redundant. The first code is weighted by 32 and the second by 8. The third code is added unweighted, and a fixed redundancy offset is then taken off. The sum is clamped into the 8-bit output range and registered in an output latch. A word for a given sample appears three clocks after that sample was taken. A new word follows on every clock. A valid flag shows which words came from a fully refilled pipeline.

Top module: `adc_pipe_aligner`

## Requirements
- R1: While `rst_n` is low, `data_out` is 0 and `data_valid` is 0, whatever the stage inputs do.
- R2: A word equals 32·c1 + 8·c2 + c3 − 20 (offset parameter default 20). Here c1 is the 3-bit first-stage code, c2 the 3-bit second-stage code and c3 the 4-bit third-stage code of one sample, all unsigned.
- R3: A combined value above 255 is output as 255, for example codes 7, 7, 15 or 7, 6, 4.
- R4: A combined value below 0 is output as 0, for example codes 0, 0, 0 or 0, 2, 3.
- R5: For the sample taken at rising edge k, the first-stage code is captured at the falling edge that follows edge k. The second-stage code is captured at rising edge k+1, and the third-stage code at the falling edge after k+1. The value an input holds outside its capture instant has no effect.
- R6: The word for the sample taken at rising edge k is on `data_out` right after rising edge k+3.
- R7: A new aligned word is produced on every rising edge without stalls, and `data_valid` never drops once set until the next reset.
- R8: After `rst_n` is released, `data_valid` is low after the first three rising edges and rises at the fourth.
- R9: While `data_valid` is low, `data_out` is 0.
- R10: A reset applied in the middle of a stream clears the pipeline. The refill then repeats the R8 sequence before new valid words appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; the sample is taken at its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg1_code | input | 3 | First-stage code, valid in the low half after the sampling edge |
| stg2_code | input | 3 | Second-stage code, valid at the next rising edge |
| stg3_code | input | 4 | Third-stage code, valid at the falling edge after that |
| data_out | output | 8 | Corrected, clamped output word |
| data_valid | output | 1 | High when data_out comes from a fully refilled pipeline |

## Verification
Hand-picked mid-range code triples check the weighting of each stage: a first-stage step moves the word by 32, a second-stage step by 8, and a third-stage step by 1. Triples around both clamp limits separate saturation from wraparound, and exact edge values (0, 1, 255, 256) show whether a limit comparison is off by one. A ramp on the third-stage code and a long pseudo-random stream check throughput and alignment. In every stream each input is overwritten with its complement as soon as its capture instant has passed, so a code captured on the wrong edge or a missing retiming stage gives a visibly wrong word. Resets at stream start and in mid-stream check the valid-flag refill timing and the zero output while invalid.

// File: rtl/adc_align_pkg.sv
package adc_align_pkg;

   // Default stage widths and the output word width
   localparam int unsigned DEF_STG1_W   = 3;
   localparam int unsigned DEF_STG2_W   = 3;
   localparam int unsigned DEF_STG3_W   = 4;
   localparam int unsigned DEF_WORD_W   = 8;
   // log2 of the residue gain between stages
   localparam int unsigned DEF_GAIN_LOG = 2;
   // Redundancy offset removed after merging
   localparam int          DEF_OFFSET   = 20;
   // Rising edges between a sample and its latched word
   localparam int unsigned PIPE_DEPTH   = 3;

   typedef enum logic {
      LIMIT_CLAMP = 1'b0,
      LIMIT_WRAP  = 1'b1
   } limit_mode_e;

endpackage

// File: rtl/adc_stage_deskew.sv
module adc_stage_deskew #(
   parameter int unsigned STG1_W = 3,
   parameter int unsigned STG2_W = 3,
   parameter int unsigned STG3_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STG1_W-1:0] stg1_in,
   input  logic [STG2_W-1:0] stg2_in,
   input  logic [STG3_W-1:0] stg3_in,
   output logic [STG1_W-1:0] stg1_al,
   output logic [STG2_W-1:0] stg2_al,
   output logic [STG3_W-1:0] stg3_al
);

   // Half-cycle captures: stage one and stage three settle mid-cycle
   logic [STG1_W-1:0] s1_fall;
   logic [STG3_W-1:0] s3_fall;
   // First rising-edge row
   logic [STG1_W-1:0] s1_row1;
   logic [STG2_W-1:0] s2_row1;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_fall <= '0;
         s3_fall <= '0;
      end else begin
         s1_fall <= stg1_in;
         s3_fall <= stg3_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_row1 <= '0;
         s2_row1 <= '0;
      end else begin
         s1_row1 <= s1_fall;
         s2_row1 <= stg2_in;
      end
   end

   // Retiming row: all three codes of one sample leave together
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg1_al <= '0;
         stg2_al <= '0;
         stg3_al <= '0;
      end else begin
         stg1_al <= s1_row1;
         stg2_al <= s2_row1;
         stg3_al <= s3_fall;
      end
   end

endmodule

// File: rtl/adc_code_merge.sv
module adc_code_merge
   import adc_align_pkg::*;
#(
   parameter int unsigned STG1_W   = 3,
   parameter int unsigned STG2_W   = 3,
   parameter int unsigned STG3_W   = 4,
   parameter int unsigned WORD_W   = 8,
   parameter int          OFFSET   = 20,
   parameter limit_mode_e LIMIT    = LIMIT_CLAMP
) (
   input  logic [STG1_W-1:0] c1,
   input  logic [STG2_W-1:0] c2,
   input  logic [STG3_W-1:0] c3,
   output logic [WORD_W-1:0] word
);

   // One redundant bit per later stage sets the digit weights
   localparam int unsigned SH3   = STG3_W - 1;
   localparam int unsigned SH2   = SH3 + STG2_W - 1;
   localparam int unsigned SUM_W = STG1_W + SH2 + 2;
   localparam int          W_MAX = (1 << WORD_W) - 1;
   localparam int          R_MAX = (((1 << STG1_W) - 1) << SH2)
                                 + (((1 << STG2_W) - 1) << SH3)
                                 + ((1 << STG3_W) - 1);

   logic signed [SUM_W-1:0] sum;

   always_comb begin
      sum = (SUM_W'(c1) << SH2) + (SUM_W'(c2) << SH3) + SUM_W'(c3)
          - SUM_W'(OFFSET);
   end

   if (LIMIT == LIMIT_CLAMP) begin : g_clamp
      always_comb begin
         if (sum < 0)
            word = '0;
         else if (sum > W_MAX)
            word = WORD_W'(W_MAX);
         else
            word = sum[WORD_W-1:0];
      end
   end else begin : g_wrap
      always_comb word = sum[WORD_W-1:0];
   end

   if (LIMIT == LIMIT_CLAMP && (R_MAX - OFFSET) > W_MAX) begin : g_chk_hi
      always_comb begin
         if (&c1 && &c2 && &c3)
            AST_CLAMP_HIGH: assert (word == WORD_W'(W_MAX)); // R3
      end
   end

   if (LIMIT == LIMIT_CLAMP && OFFSET > 0) begin : g_chk_lo
      always_comb begin
         if (c1 == '0 && c2 == '0 && c3 == '0)
            AST_CLAMP_LOW: assert (word == '0); // R4
      end
   end

endmodule

// File: rtl/adc_fill_tracker.sv
module adc_fill_tracker #(
   parameter int unsigned DEPTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic full
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0] fill_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fill_cnt <= '0;
      else if (fill_cnt != CNT_W'(DEPTH))
         fill_cnt <= fill_cnt + 1'b1;
   end

   assign full = (fill_cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/adc_pipe_aligner.sv
module adc_pipe_aligner
   import adc_align_pkg::*;
#(
   parameter int unsigned STG1_W   = DEF_STG1_W,
   parameter int unsigned STG2_W   = DEF_STG2_W,
   parameter int unsigned STG3_W   = DEF_STG3_W,
   parameter int unsigned WORD_W   = DEF_WORD_W,
   parameter int unsigned GAIN_LOG = DEF_GAIN_LOG,
   parameter int          OFFSET   = DEF_OFFSET,
   parameter limit_mode_e LIMIT    = LIMIT_CLAMP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STG1_W-1:0] stg1_code,
   input  logic [STG2_W-1:0] stg2_code,
   input  logic [STG3_W-1:0] stg3_code,
   output logic [WORD_W-1:0] data_out,
   output logic              data_valid
);

   // Elaboration checks on the parameter set
   if (STG2_W - 1 != GAIN_LOG || STG3_W - 1 <= GAIN_LOG - 1) begin : g_bad_gain
      $error("stage widths do not match the interstage gain");
   end
   if (OFFSET < 0) begin : g_bad_off
      $error("offset must not be negative");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("output word too narrow");
   end

   logic [STG1_W-1:0] a1;
   logic [STG2_W-1:0] a2;
   logic [STG3_W-1:0] a3;
   logic [WORD_W-1:0] merged;
   logic              pipe_full;

   adc_stage_deskew #(
      .STG1_W (STG1_W),
      .STG2_W (STG2_W),
      .STG3_W (STG3_W)
   ) u_deskew (
      .clk     (clk),
      .rst_n   (rst_n),
      .stg1_in (stg1_code),
      .stg2_in (stg2_code),
      .stg3_in (stg3_code),
      .stg1_al (a1),
      .stg2_al (a2),
      .stg3_al (a3)
   );

   adc_code_merge #(
      .STG1_W (STG1_W),
      .STG2_W (STG2_W),
      .STG3_W (STG3_W),
      .WORD_W (WORD_W),
      .OFFSET (OFFSET),
      .LIMIT  (LIMIT)
   ) u_merge (
      .c1   (a1),
      .c2   (a2),
      .c3   (a3),
      .word (merged)
   );

   adc_fill_tracker #(
      .DEPTH (PIPE_DEPTH)
   ) u_fill (
      .clk   (clk),
      .rst_n (rst_n),
      .full  (pipe_full)
   );

   // Output latch: partial words are held at zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_out   <= '0;
         data_valid <= 1'b0;
      end else begin
         data_out   <= pipe_full ? merged : '0;
         data_valid <= pipe_full;
      end
   end

   // Independent edge counter for the checks below
   logic [2:0] chk_age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chk_age <= '0;
      else if (chk_age != 3'd7)
         chk_age <= chk_age + 3'd1;
   end

   AST_VALID_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (chk_age >= 3'(PIPE_DEPTH + 1))); // R8

   AST_VALID_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_age >= 3'(PIPE_DEPTH + 1)) |-> data_valid); // R8

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |=> data_valid); // R7

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !data_valid |-> (data_out == '0)); // R9

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> (!data_valid && data_out == '0)); // R1

endmodule

// File: tb/adc_pipe_aligner_bench.sv
module adc_pipe_aligner_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] stg1_code = '0;
   logic [2:0] stg2_code = '0;
   logic [3:0] stg3_code = '0;
   logic [7:0] data_out;
   logic       data_valid;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   logic [2:0] v1 [64];
   logic [2:0] v2 [64];
   logic [3:0] v3 [64];

   always #4 clk = ~clk;

   adc_pipe_aligner u_adc_pipe_aligner (
      .clk        (clk),
      .rst_n      (rst_n),
      .stg1_code  (stg1_code),
      .stg2_code  (stg2_code),
      .stg3_code  (stg3_code),
      .data_out   (data_out),
      .data_valid (data_valid)
   );

   function automatic int expect_word(int a, int b, int c);
      int s;
      s = a * 32 + b * 8 + c - 20;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      return s;
   endfunction

   task automatic check(bit ok, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      #1;
      check(data_out == 8'd0, "R1/R10 data_out in reset", data_out, 0);
      check(data_valid == 1'b0, "R1/R10 data_valid in reset", data_valid, 0);
      stg1_code = 3'd5; stg2_code = 3'd6; stg3_code = 4'd9;
      repeat (2) @(posedge clk);
      #1;
      check(data_out == 8'd0, "R1 data_out held with busy inputs", data_out, 0);
      @(negedge clk);
      #1 rst_n = 1'b1;
   endtask

   // Streams samples 1..len starting at the first edge after reset.
   // Each input is complemented right after its capture instant (R5).
   task automatic run_stream(int len, bit drain, string tag);
      int last;
      last = drain ? len + 3 : len;
      for (int n = 1; n <= last; n++) begin
         @(posedge clk);
         #1;
         stg1_code = (n <= len) ? v1[n] : 3'd0;
         stg3_code = (n >= 2 && n - 1 <= len) ? v3[n-1] : 4'd0;
         stg2_code = ~stg2_code;
         #2;
         if (n >= 4) begin
            check(data_valid == 1'b1, {tag, " R7/R8 valid while streaming"},
                  data_valid, 1);
            check(int'(data_out) == expect_word(v1[n-3], v2[n-3], v3[n-3]),
                  {tag, " R2/R5/R6 word three clocks after sample"},
                  data_out, expect_word(v1[n-3], v2[n-3], v3[n-3]));
         end else begin
            check(data_valid == 1'b0, {tag, " R8/R10 valid low while refilling"},
                  data_valid, 0);
            check(data_out == 8'd0, {tag, " R9 zero while invalid"}, data_out, 0);
         end
         @(negedge clk);
         #1;
         stg1_code = ~stg1_code;
         stg3_code = ~stg3_code;
         stg2_code = (n <= len) ? v2[n] : 3'd0;
      end
   endtask

   task automatic test_midrange();
      v1[1] = 3'd4; v2[1] = 3'd3; v3[1] = 4'd8;   // 140
      v1[2] = 3'd1; v2[2] = 3'd0; v3[2] = 4'd0;   // 12
      v1[3] = 3'd0; v2[3] = 3'd2; v3[3] = 4'd5;   // 1
      v1[4] = 3'd2; v2[4] = 3'd1; v3[4] = 4'd0;   // 52
      v1[5] = 3'd2; v2[5] = 3'd0; v3[5] = 4'd8;   // 52, overlap path
      v1[6] = 3'd3; v2[6] = 3'd7; v3[6] = 4'd15;  // 147
      do_reset();
      run_stream(6, 1'b1, "R2 midrange");
   endtask

   task automatic test_limits();
      v1[1] = 3'd7; v2[1] = 3'd7; v3[1] = 4'd15;  // R3 275 -> 255
      v1[2] = 3'd7; v2[2] = 3'd6; v3[2] = 4'd4;   // R3 256 -> 255
      v1[3] = 3'd7; v2[3] = 3'd6; v3[3] = 4'd3;   // 255 exact
      v1[4] = 3'd0; v2[4] = 3'd0; v3[4] = 4'd0;   // R4 -20 -> 0
      v1[5] = 3'd0; v2[5] = 3'd2; v3[5] = 4'd3;   // R4 -1 -> 0
      v1[6] = 3'd0; v2[6] = 3'd2; v3[6] = 4'd4;   // 0 exact
      v1[7] = 3'd7; v2[7] = 3'd4; v3[7] = 4'd3;   // 239
      do_reset();
      run_stream(7, 1'b1, "R3/R4 limits");
   endtask

   task automatic test_ramp();
      for (int i = 1; i <= 16; i++) begin
         v1[i] = 3'd3; v2[i] = 3'd5; v3[i] = 4'(i - 1);
      end
      do_reset();
      run_stream(16, 1'b1, "R7 ramp");
   endtask

   task automatic test_random();
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 1; i <= 40; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         v1[i] = lf[2:0]; v2[i] = lf[7:5]; v3[i] = lf[13:10];
      end
      do_reset();
      run_stream(40, 1'b1, "R5 random");
   endtask

   task automatic test_midreset();
      for (int i = 1; i <= 10; i++) begin
         v1[i] = 3'(i); v2[i] = 3'(7 - (i % 8)); v3[i] = 4'(i + 3);
      end
      do_reset();
      run_stream(10, 1'b0, "R10 first");
      check(data_valid == 1'b1, "R10 valid before mid reset", data_valid, 1);
      for (int i = 1; i <= 8; i++) begin
         v1[i] = 3'd6; v2[i] = 3'(i % 8); v3[i] = 4'(15 - i);
      end
      do_reset();
      run_stream(8, 1'b1, "R10 refill");
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   initial begin
      test_midrange();
      test_limits();
      test_ramp();
      test_random();
      test_midreset();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

endmodule